// File: doc/BRIEF.md
# IMA Control Cell Generator

This block produces the control cell that an inverse-multiplexing link sends once in every IMA frame. It counts the cell slots of the link, one `slot_tick` per slot. When the slot number equals the configured cell offset, it streams a 53-byte control cell, one byte per clock. The first 13 bytes come from fixed header constants, from the active configuration, and from running state: the frame sequence number, the link stuff indication and the status change counter. The remaining bytes are a fill pattern followed by a two-byte trailer left at zero. CRC-10 is inserted further downstream. A frame is 32, 64, 128 or 256 slots long, chosen by a 2-bit code. At the last slot of every frame the block can raise a one-cycle interrupt pulse.

Software writes a small shadow register bank and then issues a transfer command. The shadow contents become active at the next frame boundary, so a cell is never built from a mix of old and new fields. The status change counter advances only when a transfer actually alters a field that appears in the cell. The stuff warning is computed from a configurable stuff period. It gives advance notice either one frame or four frames ahead of each stuff frame.

Top module: `ima_icp_gen`

## Requirements
- R1: A cell is 53 consecutive valid bytes, with `cell_sof` on the first and `cell_eof` on the last. Bytes 1..5 are 00 00 00 0B 64 and byte 6 is 01. Bytes 14..51 are 6A and bytes 52..53 are 00.
- R2: Byte 7 is 1 in bit 7, zeros in bits 6:5, and the link id in bits 4:0. Only the low 5 bits of a link id write are kept. Byte 12 is the group id register and byte 13 is the status register. Bits 1:0 of the status register are the frame-length code m.
- R3: The frame sequence number is 0 after reset and increments modulo 256 at each frame boundary. Byte 8 carries the number of the frame in which the cell is sent.
- R4: A frame has 32<<m slots, numbered 0..(32<<m)-1 from reset. The cell is started by the tick of the slot whose number equals the offset register. Its first byte is visible in the cycle after that tick's clock edge, and byte 9 carries the offset.
- R5: Byte 11, the status change counter, is 0 after reset. It increments by one at a frame boundary that applies a transfer in which the link, offset, group or status register differs from the active value. Otherwise it is unchanged.
- R6: Register writes have no effect on cells until a transfer command. The transfer takes effect at the next frame boundary, which is the tick of slot (32<<m)-1.
- R7: Byte 10 is the stuff code in bits 2:0. A stuff countdown k is reloaded at each applied transfer with the new stuff period P. At every other boundary k is reloaded with P when k is 0 and decremented otherwise. The code is 7 when P=0 and 6 when k=0. In one-frame mode (control bit 0 clear) the code is 0 when k=1 and 7 for any other k.
- R8: In four-frame mode (control bit 0 set) the code is k-1 for k in 1..4 and 7 for larger k.
- R9: `frame_irq` is high for exactly the one cycle after a boundary tick's edge, and only when control bit 1 was set before that edge.
- R10: During and right after reset all outputs are 0, all registers are 0, and m is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Shadow register write strobe |
| cfg_addr | input | 3 | Register: 0 link, 1 offset, 2 group, 3 status, 4 stuff period, 5 control |
| cfg_wdata | input | 8 | Write data |
| cfg_xfer | input | 1 | Transfer command: apply shadow at next boundary |
| slot_tick | input | 1 | One pulse per cell slot of the link |
| cell_valid | output | 1 | Cell byte valid |
| cell_sof | output | 1 | First byte of cell |
| cell_eof | output | 1 | Last byte of cell |
| cell_byte | output | 8 | Cell byte |
| frame_irq | output | 1 | End-of-frame interrupt pulse |

## Verification
All outputs are registered. Byte n of a cell (1-based) therefore appears n clock edges after the edge that sampled the starting tick, and the interrupt appears one edge after the boundary tick. The bench drives inputs on falling edges. It samples the first byte and the interrupt at the next falling edge, then samples one byte per following falling edge. After the last byte it checks that `cell_valid` has dropped and that the interrupt lasted a single cycle. Configuration is always written between ticks, so the model can apply it at the boundary tick that follows.

// File: rtl/ima_icp_pkg.sv
package ima_icp_pkg;
  localparam int CELL_FIELDS = 13;

  typedef enum logic [2:0] {
    REG_LINK   = 3'd0,
    REG_OFFSET = 3'd1,
    REG_GROUP  = 3'd2,
    REG_STATUS = 3'd3,
    REG_STUFF  = 3'd4,
    REG_CTRL   = 3'd5
  } reg_sel_e;

  typedef struct packed {
    logic [7:0] link;
    logic [7:0] offset;
    logic [7:0] group;
    logic [7:0] status;
    logic [7:0] stuff;
    logic [7:0] ctrl;
  } icp_cfg_t;

  localparam logic [2:0] LSI_IDLE = 3'b111;
  localparam logic [2:0] LSI_HERE = 3'b110;
endpackage

// File: rtl/ima_icp_cfg.sv
module ima_icp_cfg
  import ima_icp_pkg::*;
#(
  parameter int LINK_W = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       xfer,
  input  logic       boundary,
  output icp_cfg_t   act,
  output logic       apply,
  output logic [7:0] next_stuff,
  output logic [7:0] chg_cnt
);
  icp_cfg_t shadow;
  logic     pending;
  logic     visible_diff;

  assign apply      = boundary && pending;
  assign next_stuff = shadow.stuff;
  assign visible_diff = {shadow.link, shadow.offset, shadow.group, shadow.status} !=
                        {act.link, act.offset, act.group, act.status};

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow  <= '0;
      act     <= '0;
      pending <= 1'b0;
      chg_cnt <= '0;
    end else begin
      if (wr_en) begin
        case (reg_sel_e'(wr_addr))
          REG_LINK:   shadow.link   <= 8'(wr_data[LINK_W-1:0]);
          REG_OFFSET: shadow.offset <= wr_data;
          REG_GROUP:  shadow.group  <= wr_data;
          REG_STATUS: shadow.status <= wr_data;
          REG_STUFF:  shadow.stuff  <= wr_data;
          REG_CTRL:   shadow.ctrl   <= wr_data;
          default: ;
        endcase
      end
      if (apply) begin
        act     <= shadow;
        pending <= 1'b0;
        if (visible_diff) chg_cnt <= chg_cnt + 8'd1;
      end
      if (xfer) pending <= 1'b1;
    end
  end
endmodule

// File: rtl/ima_icp_timing.sv
module ima_icp_timing
  import ima_icp_pkg::*;
#(
  parameter int BASE_SLOTS = 32,
  parameter int SLOT_W     = $clog2(BASE_SLOTS * 8),
  parameter int SEQ_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [1:0]        m_code,
  input  logic [SLOT_W-1:0] offset,
  input  logic [7:0]        stuff_period,
  input  logic              early4,
  input  logic              irq_en,
  input  logic              apply,
  input  logic [7:0]        next_stuff,
  output logic              start,
  output logic              boundary,
  output logic [SEQ_W-1:0]  seq,
  output logic [2:0]        lsi,
  output logic              frame_irq
);
  localparam int FL_W = SLOT_W + 1;

  logic [SLOT_W-1:0] slot;
  logic [FL_W-1:0]   flen;
  logic [SLOT_W-1:0] last_slot;
  logic [7:0]        k;
  logic [7:0]        warn_win;

  always_comb begin
    flen      = FL_W'(BASE_SLOTS) << m_code;
    last_slot = SLOT_W'(flen - FL_W'(1));
  end

  assign start    = tick && (slot == offset);
  assign boundary = tick && (slot == last_slot);
  assign warn_win = early4 ? 8'd4 : 8'd1;

  always_comb begin
    if (stuff_period == 8'd0)   lsi = LSI_IDLE;
    else if (k == 8'd0)         lsi = LSI_HERE;
    else if (k <= warn_win)     lsi = 3'(k - 8'd1);
    else                        lsi = LSI_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot      <= '0;
      seq       <= '0;
      k         <= '0;
      frame_irq <= 1'b0;
    end else begin
      frame_irq <= boundary && irq_en;
      if (tick) slot <= boundary ? '0 : slot + SLOT_W'(1);
      if (boundary) begin
        seq <= seq + SEQ_W'(1);
        if (apply)           k <= next_stuff;
        else if (k == 8'd0)  k <= stuff_period;
        else                 k <= k - 8'd1;
      end
    end
  end
endmodule

// File: rtl/ima_icp_stream.sv
module ima_icp_stream #(
  parameter int         CELL_BYTES = 53,
  parameter int         NFIELD     = 13,
  parameter int         TRAIL      = 2,
  parameter logic [7:0] FILL_BYTE  = 8'h6A
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [NFIELD-1:0][7:0] fields,
  output logic                  valid,
  output logic                  sof,
  output logic                  eof,
  output logic [7:0]            data
);
  localparam int IDX_W = $clog2(CELL_BYTES);
  localparam int FW    = $clog2(NFIELD);

  logic [NFIELD-1:0][7:0] snap;
  logic [IDX_W-1:0]       idx;
  logic                   busy;
  logic [7:0]             nxt;

  always_comb begin
    nxt = FILL_BYTE;
    if (idx < IDX_W'(NFIELD))                      nxt = snap[FW'(idx)];
    else if (idx >= IDX_W'(CELL_BYTES - TRAIL))    nxt = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap  <= '0;
      idx   <= '0;
      busy  <= 1'b0;
      valid <= 1'b0;
      sof   <= 1'b0;
      eof   <= 1'b0;
      data  <= '0;
    end else if (start) begin
      snap  <= fields;
      data  <= fields[0];
      valid <= 1'b1;
      sof   <= 1'b1;
      eof   <= 1'b0;
      idx   <= IDX_W'(1);
      busy  <= 1'b1;
    end else if (busy) begin
      data  <= nxt;
      valid <= 1'b1;
      sof   <= 1'b0;
      eof   <= (idx == IDX_W'(CELL_BYTES - 1));
      if (idx == IDX_W'(CELL_BYTES - 1)) busy <= 1'b0;
      idx   <= idx + IDX_W'(1);
    end else begin
      data  <= '0;
      valid <= 1'b0;
      sof   <= 1'b0;
      eof   <= 1'b0;
    end
  end
endmodule

// File: rtl/ima_icp_gen.sv
module ima_icp_gen
  import ima_icp_pkg::*;
#(
  parameter int          CELL_BYTES = 53,
  parameter int          LINK_W     = 5,
  parameter int          BASE_SLOTS = 32,
  parameter logic [39:0] HDR        = 40'h00_00_00_0B_64,
  parameter logic [7:0]  OAM_LABEL  = 8'h01,
  parameter logic [7:0]  FILL_BYTE  = 8'h6A
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_we,
  input  logic [2:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  input  logic       cfg_xfer,
  input  logic       slot_tick,
  output logic       cell_valid,
  output logic       cell_sof,
  output logic       cell_eof,
  output logic [7:0] cell_byte,
  output logic       frame_irq
);
  localparam int SLOT_W = $clog2(BASE_SLOTS * 8);
  localparam int HDR_N  = 5;

  icp_cfg_t   act;
  logic       apply, start, boundary, irq_en_act;
  logic [7:0] next_stuff, scci, fsn;
  logic [2:0] lsi;
  logic [CELL_FIELDS-1:0][7:0] fields;

  assign irq_en_act = act.ctrl[1];

  ima_icp_cfg #(.LINK_W(LINK_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
    .xfer(cfg_xfer), .boundary(boundary), .act(act), .apply(apply),
    .next_stuff(next_stuff), .chg_cnt(scci)
  );

  ima_icp_timing #(.BASE_SLOTS(BASE_SLOTS), .SLOT_W(SLOT_W), .SEQ_W(8)) u_tim (
    .clk(clk), .rst(rst), .tick(slot_tick), .m_code(act.status[1:0]),
    .offset(SLOT_W'(act.offset)), .stuff_period(act.stuff), .early4(act.ctrl[0]),
    .irq_en(irq_en_act), .apply(apply), .next_stuff(next_stuff),
    .start(start), .boundary(boundary), .seq(fsn), .lsi(lsi), .frame_irq(frame_irq)
  );

  for (genvar g = 0; g < HDR_N; g++) begin : g_hdr
    assign fields[g] = HDR[8*(HDR_N-1-g) +: 8];
  end

  assign fields[5]  = OAM_LABEL;
  assign fields[6]  = {1'b1, 7'(act.link[LINK_W-1:0])};
  assign fields[7]  = fsn;
  assign fields[8]  = act.offset;
  assign fields[9]  = {5'b0, lsi};
  assign fields[10] = scci;
  assign fields[11] = act.group;
  assign fields[12] = act.status;

  ima_icp_stream #(
    .CELL_BYTES(CELL_BYTES), .NFIELD(CELL_FIELDS), .TRAIL(2), .FILL_BYTE(FILL_BYTE)
  ) u_str (
    .clk(clk), .rst(rst), .start(start), .fields(fields),
    .valid(cell_valid), .sof(cell_sof), .eof(cell_eof), .data(cell_byte)
  );
endmodule

// File: rtl/ima_icp_chk.sv
module ima_icp_chk #(
  parameter int CELL_BYTES = 53
) (
  input logic       clk,
  input logic       rst,
  input logic       slot_tick,
  input logic       cell_valid,
  input logic       cell_sof,
  input logic       cell_eof,
  input logic       frame_irq,
  input logic [7:0] fsn,
  input logic [7:0] scci,
  input logic       irq_en_act
);
  int unsigned seen;

  always_ff @(posedge clk) begin
    if (rst)             seen <= 0;
    else if (cell_sof)   seen <= 1;
    else if (cell_valid) seen <= seen + 1;
  end

  p_sof_valid_r1: assert property (@(posedge clk) disable iff (rst)
    (cell_sof || cell_eof) |-> cell_valid);

  p_cell_length_r1: assert property (@(posedge clk) disable iff (rst)
    (cell_eof && !cell_sof) |-> (seen == CELL_BYTES - 1));

  p_cell_contig_r1: assert property (@(posedge clk) disable iff (rst)
    (cell_valid && !cell_eof) |=> cell_valid);

  p_fsn_step_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(fsn) |-> (fsn == $past(fsn) + 8'd1));

  p_sof_from_tick_r4: assert property (@(posedge clk) disable iff (rst)
    cell_sof |-> $past(slot_tick));

  p_scci_step_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(scci) |-> (scci == $past(scci) + 8'd1));

  p_irq_single_r9: assert property (@(posedge clk) disable iff (rst)
    frame_irq |=> !frame_irq);

  p_irq_enabled_r9: assert property (@(posedge clk) disable iff (rst)
    frame_irq |-> $past(irq_en_act));
endmodule

bind ima_icp_gen ima_icp_chk #(.CELL_BYTES(CELL_BYTES)) u_chk (
  .clk(clk), .rst(rst), .slot_tick(slot_tick), .cell_valid(cell_valid),
  .cell_sof(cell_sof), .cell_eof(cell_eof), .frame_irq(frame_irq),
  .fsn(fsn), .scci(scci), .irq_en_act(irq_en_act)
);

// File: tb/tb_ima_icp_gen.sv
`timescale 1ns/1ps
module tb_ima_icp_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0, cfg_xfer = 1'b0, slot_tick = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic cell_valid, cell_sof, cell_eof, frame_irq;
  logic [7:0] cell_byte;

  always #2.5 clk = ~clk;

  ima_icp_gen dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_xfer(cfg_xfer), .slot_tick(slot_tick), .cell_valid(cell_valid),
    .cell_sof(cell_sof), .cell_eof(cell_eof), .cell_byte(cell_byte), .frame_irq(frame_irq)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // reference model state
  int slot = 0, fsn = 0, k = 0, scci = 0, frames = 0;
  int act[6] = '{0, 0, 0, 0, 0, 0};
  int shd[6] = '{0, 0, 0, 0, 0, 0};
  bit pend = 1'b0;

  task automatic chk(input bit ok, input string req, input int a, input int e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, a, e);
    end
  endtask

  function automatic int flen();
    return 32 << (act[3] & 3);
  endfunction

  function automatic int exp_lsi();
    int w = (act[5] & 1) ? 4 : 1;
    if (act[4] == 0) return 7;
    if (k == 0) return 6;
    if (k <= w) return k - 1;
    return 7;
  endfunction

  function automatic int exp_byte(input int i);
    case (i)
      0, 1, 2: return 8'h00;
      3: return 8'h0B;
      4: return 8'h64;
      5: return 8'h01;
      6: return 8'h80 | act[0];
      7: return fsn;
      8: return act[1];
      9: return exp_lsi();
      10: return scci;
      11: return act[2];
      12: return act[3];
      default: return (i >= 51) ? 0 : 8'h6A;
    endcase
  endfunction

  function automatic string tag(input int i);
    case (i)
      6, 11, 12: return "R2";
      7: return "R3";
      8: return "R4";
      9: return ((act[5] & 1) != 0) ? "R8" : "R7";
      10: return "R5";
      default: return "R1";
    endcase
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 8'(d);
    @(negedge clk);
    cfg_we = 1'b0;
    shd[a] = (a == 0) ? (d & 8'h1F) : (d & 8'hFF);
  endtask

  task automatic xfer();
    @(negedge clk);
    cfg_xfer = 1'b1;
    @(negedge clk);
    cfg_xfer = 1'b0;
    pend = 1'b1;
  endtask

  task automatic step();
    bit st = (slot == act[1]);
    bit bd = (slot == flen() - 1);
    int eb[53];
    for (int i = 0; i < 53; i++) eb[i] = exp_byte(i);
    @(negedge clk);
    slot_tick = 1'b1;
    @(negedge clk);
    slot_tick = 1'b0;
    // R9: pulse visible one edge after the boundary tick
    chk(frame_irq == (bd && (act[5] & 2) != 0), "R9 irq", frame_irq, bd && (act[5] & 2) != 0);
    if (st) begin
      chk(cell_valid && cell_sof && !cell_eof, "R4 start", {cell_valid, cell_sof, cell_eof}, 3'b110);
      chk(cell_byte == 8'(eb[0]), "R1 byte1", cell_byte, eb[0]);
      for (int i = 1; i < 53; i++) begin
        @(negedge clk);
        if (i == 1) chk(!frame_irq, "R9 one cycle", frame_irq, 0);
        chk(cell_valid && !cell_sof && (cell_eof == (i == 52)), "R1 framing",
            {cell_valid, cell_sof, cell_eof}, {1'b1, 1'b0, i == 52});
        chk(cell_byte == 8'(eb[i]), tag(i), cell_byte, eb[i]);
      end
      @(negedge clk);
      chk(!cell_valid, "R1 end", cell_valid, 0);
    end else begin
      chk(!cell_valid, "R4 no cell", cell_valid, 0);
      @(negedge clk);
      chk(!frame_irq, "R9 one cycle", frame_irq, 0);
    end
    // model update
    if (bd) begin
      fsn = (fsn + 1) % 256;
      frames++;
      if (pend) begin
        bit diff = 1'b0;
        for (int r = 0; r < 4; r++) if (shd[r] != act[r]) diff = 1'b1;
        if (diff) scci = (scci + 1) % 256;
        k = shd[4];
        for (int r = 0; r < 6; r++) act[r] = shd[r];
        pend = 1'b0;
      end else if (k == 0) k = act[4];
      else k = k - 1;
      slot = 0;
    end else slot++;
  endtask

  task automatic run_frames(input int n);
    for (int f = 0; f < n; f++) begin
      int len = flen();
      for (int s = 0; s < len; s++) step();
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({cell_valid, cell_sof, cell_eof, frame_irq, cell_byte} == '0, "R10 in reset",
        {cell_valid, cell_sof, cell_eof, frame_irq, cell_byte}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({cell_valid, cell_sof, cell_eof, frame_irq, cell_byte} == '0, "R10 after reset",
        {cell_valid, cell_sof, cell_eof, frame_irq, cell_byte}, 0);

    run_frames(1);                      // R10 defaults, R3 fsn 0
    wr(0, 8'hE5); wr(1, 3); wr(2, 8'h4C); wr(3, 8'hA4); wr(4, 5); wr(5, 2);
    run_frames(1);                      // R6 writes alone have no effect
    xfer();
    run_frames(8);                      // R5 change, R7 one-frame stuff codes
    xfer();
    run_frames(1);                      // R5 identical transfer keeps counter
    wr(4, 6); wr(5, 3); xfer();
    run_frames(9);                      // R8 four-frame warnings, R5 no visible change
    wr(1, 31); xfer();
    run_frames(2);                      // R4 cell on boundary slot
    wr(3, 8'hA5); wr(1, 40); xfer();
    run_frames(3);                      // R4 64-slot frames
    wr(3, 8'hA4); wr(1, 7); wr(5, 1); xfer();
    run_frames(2);                      // R9 interrupt disabled
    wr(5, 3); wr(4, 2); xfer();
    while (frames < 262) run_frames(1); // R3 sequence wrap
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule